// File: doc/BRIEF.md
# Cache line decay controller

This block decides when each line of a small cache has been idle long enough that its supply should be switched off to save leakage. Time is kept at two levels. A shared tick generator emits a one-cycle pulse every `TICK_PERIOD` clocks. Each line holds a 2-bit saturating idle count that moves on those ticks. Any lookup or fill of a line clears its count. A line whose count is already at its top value when another step arrives is decayed. Its power-enable output drops and its valid output clears, so the next lookup of that line misses.

In adaptive mode each line keeps an interval exponent `e`. Its idle count then steps once per `2^e` ticks instead of once per tick. After a live line decays, the line enters a watch state. If a lookup of the line arrives before the line's first post-decay step, the decay was premature and the exponent grows. If that step arrives first, the exponent shrinks. The tag array, data array and next cache level are not part of the block. The cache reports lookups and fills on the strobe ports and uses the power and valid vectors.

Each line runs a four-state machine:
- `LN_EMPTY`: powered and invalid.
- `LN_LIVE`: powered and valid.
- `LN_WATCH`: unpowered, judging the decay.
- `LN_ASLEEP`: unpowered, judgement done.

The transitions are:
- *fill*: any state goes to `LN_LIVE`.
- *idle decay*: `LN_EMPTY` or `LN_LIVE` goes to `LN_ASLEEP`. A live line goes to `LN_WATCH` instead when adaptive mode is on.
- *quick miss*: `LN_WATCH` goes to `LN_ASLEEP`, and the exponent grows by one.
- *slow miss*: `LN_WATCH` goes to `LN_ASLEEP`, and the exponent shrinks by one.

Top module: `cache_decay_ctl`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge), every line is in `LN_EMPTY`: `pwr_en` is all ones, `line_valid` is all zeros, `decay_evt` is 0, and every exponent is 0.
- R2: The tick fires in the cycle in which a free-running counter, cleared by reset, holds `TICK_PERIOD-1`. The counter then wraps to 0, so ticks are exactly `TICK_PERIOD` cycles apart.
- R3: A lookup (`acc_valid` with `acc_idx`) or a fill of a powered line clears that line's idle count and its tick sub-count.
- R4: In fixed mode (`adapt_en`=0), a powered line decays at the edge of the fourth tick with no lookup or fill. From the next cycle its `pwr_en` bit and `line_valid` bit are 0.
- R5: `decay_evt` is high for exactly the one cycle after a decay edge. `decay_idx` then gives the lowest index among the lines that decayed at that edge.
- R6: A fill (`fill_valid` with `fill_idx`) drives that line's `pwr_en` bit high in the same cycle, whatever the line's state. `line_valid` of the line is 1 from the next cycle.
- R7: A fill and a lookup of the same line in the same cycle act as a fill. A lookup of an unpowered line changes neither its `pwr_en` bit nor its `line_valid` bit.
- R8: In adaptive mode (`adapt_en`=1), a line with exponent `e` advances its idle count once every `2^e` ticks.
- R9: A lookup of a line in `LN_WATCH` is a quick miss. It raises the exponent by one, up to a limit of `MAX_EXP` (6, that is 64 ticks per step), and moves the line to `LN_ASLEEP`.
- R10: If a line in `LN_WATCH` reaches its first step without a lookup, the exponent drops by one, down to a limit of 0, and the line moves to `LN_ASLEEP`.
- R11: A line in `LN_EMPTY` also decays after idling, always to `LN_ASLEEP`, and its exponent is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| adapt_en | input | 1 | 1 selects the adaptive interval per line |
| acc_valid | input | 1 | Lookup strobe |
| acc_idx | input | $clog2(NUM_LINES) | Line index of the lookup |
| fill_valid | input | 1 | Fill strobe |
| fill_idx | input | $clog2(NUM_LINES) | Line index of the fill |
| pwr_en | output | NUM_LINES | Supply enable per line |
| line_valid | output | NUM_LINES | Valid bit per line |
| decay_evt | output | 1 | One-cycle pulse after a decay edge |
| decay_idx | output | $clog2(NUM_LINES) | Lowest index decayed at that edge |

## Verification
The situation hardest to reach from the ports is an exponent pinned at either limit. Reaching it takes a long chain of decay and refill rounds. In each round a lookup must land inside the short watch window that follows a decay, or must be held back until that window closes. The bench repeats fill, idle-until-decay and an immediate lookup until the exponent must have hit 6, so the idle time grows to 64 ticks per step. It then repeats fill, decay and a wait that outlasts the watch window until the exponent must be back at 0. Its model predicts every decay cycle and compares the outputs against it, so an exponent stuck short of a limit or moved past one shows up as a wrong decay time.

// File: rtl/decay_pkg.sv
package decay_pkg;
    typedef enum logic [1:0] {
        LN_EMPTY  = 2'd0,
        LN_LIVE   = 2'd1,
        LN_WATCH  = 2'd2,
        LN_ASLEEP = 2'd3
    } line_state_e;
endpackage

// File: rtl/decay_tick_gen.sv
module decay_tick_gen #(
    parameter int PERIOD = 2500
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst)                phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                    phase <= phase + CW'(1);
    end

    always_comb tick = (phase == LAST);

    generate
        if (PERIOD > 1) begin : g_gap_chk
            p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/decay_line.sv
module decay_line
    import decay_pkg::*;
#(
    parameter int CNT_W   = 2,
    parameter int MAX_EXP = 6,
    parameter int EXP_W   = 3,
    parameter int SUB_W   = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic adapt_en,
    input  logic acc_hit,
    input  logic fill_hit,
    output logic pwr_on,
    output logic valid_o,
    output logic decay_now
);
    localparam logic [EXP_W-1:0] EXP_TOP = EXP_W'(MAX_EXP);

    line_state_e      st, st_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [SUB_W-1:0] sub, sub_n;
    logic [EXP_W-1:0] ex, ex_n;
    logic [SUB_W-1:0] sub_lim;
    logic             step;

    always_comb begin
        sub_lim = ~({SUB_W{1'b1}} << ex);
        step    = !adapt_en || (sub == sub_lim);
    end

    always_comb begin
        st_n      = st;
        cnt_n     = cnt;
        sub_n     = sub;
        ex_n      = ex;
        decay_now = 1'b0;
        if (fill_hit) begin
            st_n  = LN_LIVE;
            cnt_n = '0;
            sub_n = '0;
        end else begin
            unique case (st)
                LN_EMPTY, LN_LIVE: begin
                    if (acc_hit) begin
                        cnt_n = '0;
                        sub_n = '0;
                    end else if (tick) begin
                        if (!step) begin
                            sub_n = sub + SUB_W'(1);
                        end else begin
                            sub_n = '0;
                            if (&cnt) begin
                                decay_now = 1'b1;
                                cnt_n     = '0;
                                st_n      = (st == LN_LIVE && adapt_en) ? LN_WATCH : LN_ASLEEP;
                            end else begin
                                cnt_n = cnt + CNT_W'(1);
                            end
                        end
                    end
                end
                LN_WATCH: begin
                    if (acc_hit) begin
                        if (ex < EXP_TOP) ex_n = ex + EXP_W'(1);
                        st_n = LN_ASLEEP;
                    end else if (tick) begin
                        if (step) begin
                            sub_n = '0;
                            if (ex != '0) ex_n = ex - EXP_W'(1);
                            st_n = LN_ASLEEP;
                        end else begin
                            sub_n = sub + SUB_W'(1);
                        end
                    end
                end
                LN_ASLEEP: begin
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= LN_EMPTY;
            cnt <= '0;
            sub <= '0;
            ex  <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
            sub <= sub_n;
            ex  <= ex_n;
        end
    end

    always_comb begin
        unique case (st)
            LN_EMPTY:  begin pwr_on = 1'b1;     valid_o = 1'b0; end
            LN_LIVE:   begin pwr_on = 1'b1;     valid_o = 1'b1; end
            LN_WATCH:  begin pwr_on = fill_hit; valid_o = 1'b0; end
            LN_ASLEEP: begin pwr_on = fill_hit; valid_o = 1'b0; end
            default:   begin pwr_on = 1'b1;     valid_o = 1'b0; end
        endcase
    end

    p_fill_valid_r6: assert property (@(posedge clk) disable iff (rst)
        fill_hit |=> valid_o);
    p_decay_dark_r4: assert property (@(posedge clk) disable iff (rst)
        decay_now |=> (!valid_o && !$past(fill_hit)));
    // R9 and R10: the exponent moves only while the line is judging a decay
    p_exp_in_watch_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(ex) |-> ($past(st) == LN_WATCH));
    p_exp_bound_r10: assert property (@(posedge clk) disable iff (rst)
        ex <= EXP_TOP);
endmodule

// File: rtl/decay_report.sv
module decay_report #(
    parameter int NUM_LINES = 8,
    parameter int IDX_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] dec_vec,
    output logic                 evt,
    output logic [IDX_W-1:0]     idx
);
    logic [IDX_W-1:0] low_idx;

    always_comb begin
        low_idx = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (dec_vec[i]) low_idx = IDX_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            evt <= 1'b0;
            idx <= '0;
        end else begin
            evt <= |dec_vec;
            idx <= low_idx;
        end
    end
endmodule

// File: rtl/cache_decay_ctl.sv
module cache_decay_ctl #(
    parameter int NUM_LINES   = 8,
    parameter int TICK_PERIOD = 2500,
    parameter int CNT_W       = 2,
    parameter int MAX_EXP     = 6,
    parameter int IDX_W       = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 adapt_en,
    input  logic                 acc_valid,
    input  logic [IDX_W-1:0]     acc_idx,
    input  logic                 fill_valid,
    input  logic [IDX_W-1:0]     fill_idx,
    output logic [NUM_LINES-1:0] pwr_en,
    output logic [NUM_LINES-1:0] line_valid,
    output logic                 decay_evt,
    output logic [IDX_W-1:0]     decay_idx
);
    localparam int EXP_W = $clog2(MAX_EXP + 1);
    localparam int SUB_W = MAX_EXP;

    logic                 tick;
    logic [NUM_LINES-1:0] dec_vec;

    decay_tick_gen #(.PERIOD(TICK_PERIOD)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    generate
        for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
            logic a_hit, f_hit;
            always_comb begin
                a_hit = acc_valid  && (acc_idx  == IDX_W'(g));
                f_hit = fill_valid && (fill_idx == IDX_W'(g));
            end
            decay_line #(
                .CNT_W   (CNT_W),
                .MAX_EXP (MAX_EXP),
                .EXP_W   (EXP_W),
                .SUB_W   (SUB_W)
            ) u_line (
                .clk       (clk),
                .rst       (rst),
                .tick      (tick),
                .adapt_en  (adapt_en),
                .acc_hit   (a_hit),
                .fill_hit  (f_hit),
                .pwr_on    (pwr_en[g]),
                .valid_o   (line_valid[g]),
                .decay_now (dec_vec[g])
            );
        end
    endgenerate

    decay_report #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_report (
        .clk     (clk),
        .rst     (rst),
        .dec_vec (dec_vec),
        .evt     (decay_evt),
        .idx     (decay_idx)
    );

    p_evt_dark_r5: assert property (@(posedge clk) disable iff (rst)
        decay_evt |-> (!pwr_en[decay_idx] || (fill_valid && fill_idx == decay_idx)));
    p_valid_powered_r4: assert property (@(posedge clk) disable iff (rst)
        (line_valid & ~pwr_en) == '0);
endmodule

// File: tb/test_cache_decay_ctl.sv
module test_cache_decay_ctl;
    localparam int N  = 4;
    localparam int P  = 4;
    localparam int IW = 2;
    localparam int MX = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          adapt_en = 1'b0;
    logic          acc_valid = 1'b0;
    logic [IW-1:0] acc_idx = '0;
    logic          fill_valid = 1'b0;
    logic [IW-1:0] fill_idx = '0;
    logic [N-1:0]  pwr_en, line_valid;
    logic          decay_evt;
    logic [IW-1:0] decay_idx;

    always #5 clk = ~clk;

    cache_decay_ctl #(.NUM_LINES(N), .TICK_PERIOD(P), .MAX_EXP(MX)) i_cache_decay_ctl (
        .clk(clk), .rst(rst), .adapt_en(adapt_en),
        .acc_valid(acc_valid), .acc_idx(acc_idx),
        .fill_valid(fill_valid), .fill_idx(fill_idx),
        .pwr_en(pwr_en), .line_valid(line_valid),
        .decay_evt(decay_evt), .decay_idx(decay_idx)
    );

    // behavioural model: 0 empty, 1 live, 2 watch, 3 asleep
    int m_st[N], m_cnt[N], m_sub[N], m_ex[N];
    int m_phase;
    bit m_evt;
    int m_idx;
    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    task automatic chk(input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic model_update();
        bit tick_m, any;
        int low;
        tick_m = (m_phase == P - 1);
        any = 0; low = 0;
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                m_st[i] = 0; m_cnt[i] = 0; m_sub[i] = 0; m_ex[i] = 0;
            end
            m_phase = 0; m_evt = 0; m_idx = 0;
            return;
        end
        for (int i = 0; i < N; i++) begin
            bit fh, ah, stp;
            fh  = fill_valid && fill_idx == i;
            ah  = acc_valid && acc_idx == i;
            stp = !adapt_en || (m_sub[i] == (1 << m_ex[i]) - 1);
            if (fh) begin
                m_st[i] = 1; m_cnt[i] = 0; m_sub[i] = 0;
            end else if (m_st[i] <= 1) begin
                if (ah) begin
                    m_cnt[i] = 0; m_sub[i] = 0;
                end else if (tick_m) begin
                    if (!stp) m_sub[i]++;
                    else begin
                        m_sub[i] = 0;
                        if (m_cnt[i] == 3) begin
                            if (!any) low = i;
                            any = 1;
                            m_cnt[i] = 0;
                            m_st[i] = (m_st[i] == 1 && adapt_en) ? 2 : 3;
                        end else m_cnt[i]++;
                    end
                end
            end else if (m_st[i] == 2) begin
                if (ah) begin
                    if (m_ex[i] < MX) m_ex[i]++;
                    m_st[i] = 3;
                end else if (tick_m) begin
                    if (stp) begin
                        m_sub[i] = 0;
                        if (m_ex[i] > 0) m_ex[i]--;
                        m_st[i] = 3;
                    end else m_sub[i]++;
                end
            end
        end
        m_phase = tick_m ? 0 : m_phase + 1;
        m_evt = any;
        m_idx = any ? low : m_idx;
    endtask

    task automatic cyc(input bit r, input bit av, input int ai, input bit fv, input int fi);
        logic [N-1:0] e_pwr, e_val;
        @(negedge clk);
        rst = r; acc_valid = av; acc_idx = IW'(ai); fill_valid = fv; fill_idx = IW'(fi);
        #4;
        if (!r) begin
            for (int i = 0; i < N; i++) begin
                e_pwr[i] = (m_st[i] <= 1) || (fv && fi == i);
                e_val[i] = (m_st[i] == 1);
            end
            chk("pwr_en", int'(pwr_en), int'(e_pwr));
            chk("line_valid", int'(line_valid), int'(e_val));
            chk("decay_evt", int'(decay_evt), int'(m_evt));
            if (m_evt) chk("decay_idx", int'(decay_idx), m_idx);
        end
        @(posedge clk);
        model_update();
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0);
    endtask

    task automatic until_dark(input int ln);
        for (int k = 0; k < 5000 && m_st[ln] <= 1; k++) cyc(0, 0, 0, 0, 0);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            m_st[i] = 0; m_cnt[i] = 0; m_sub[i] = 0; m_ex[i] = 0;
        end
        m_phase = 0; m_evt = 0; m_idx = 0;
        cyc(1, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0);
        // R1: reset state read at the ports
        cur_req = "R1";
        #1;
        chk("pwr_en reset", int'(pwr_en), (1 << N) - 1);
        chk("line_valid reset", int'(line_valid), 0);
        chk("decay_evt reset", int'(decay_evt), 0);
        // R2, R11, R5: all empty lines decay at once; lowest index reported
        cur_req = "R11";
        idle(4 * P + 3);
        // R6: fill wakes an asleep line in the same cycle
        cur_req = "R6";
        cyc(0, 0, 0, 1, 0);
        cyc(0, 0, 0, 1, 2);
        cyc(0, 0, 0, 1, 3);
        // R3: keep line 0 alive with lookups while 2 and 3 time out
        cur_req = "R3";
        for (int k = 0; k < 8; k++) begin
            idle(2 * P + 1);
            cyc(0, 1, 0, 0, 0);
        end
        // R4, R5: line 0 decays in fixed mode after four ticks
        cur_req = "R4";
        until_dark(0);
        idle(2);
        // R7: lookup of a dark line has no effect; fill and lookup together
        cur_req = "R7";
        cyc(0, 1, 1, 0, 0);
        cyc(0, 1, 1, 0, 0);
        cyc(0, 1, 1, 1, 1);
        idle(3);
        cur_req = "R2";
        idle(6 * P);
        // R8, R9: adaptive quick misses push the exponent to its limit
        adapt_en = 1'b1;
        cur_req = "R9";
        for (int k = 0; k < MX + 2; k++) begin
            cyc(0, 0, 0, 1, 1);
            until_dark(1);
            cyc(0, 1, 1, 0, 0);
        end
        cur_req = "R8";
        cyc(0, 0, 0, 1, 1);
        until_dark(1);
        // R10: no quick miss, exponent walks back to zero
        cur_req = "R10";
        for (int k = 0; k < MX + 2; k++) begin
            for (int w = 0; w < 20000 && m_st[1] == 2; w++) cyc(0, 0, 0, 0, 0);
            cyc(0, 0, 0, 1, 1);
            until_dark(1);
        end
        idle(4 * P);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog %s: actual timeout expected completion", cur_req);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule